// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block watches write cycles on an 8-bit data, 20-bit address parallel bus and recognises the keyed command sequences a parallel flash array accepts. Each bus write reaches the decoder as a single-cycle strobe carrying its address and data. A command begins with a two-cycle unlock key. A third cycle then either arms a byte program, opens a second three-cycle key for the erase family, or switches to identification mode. The decoder reports each recognised command as a one-cycle pulse. A program pulse carries the target address and data. A sector or block erase pulse carries the index of the region to erase.

While identification mode is active, the read port returns a manufacturer byte or a device byte, selected by address bit 0. Every other address returns zero. A busy input from the array sequencer blocks every write while an internal operation runs, including the write that would leave identification mode. The decoder holds no array storage and measures no operation time.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read mode with identification mode off, no partial sequence held, and every pulse output low.
- R2: The writes AAh@AAAh, 55h@555h, A0h@AAAh, followed by a fourth write of any address and data, raise prog_pulse for one cycle in the clock cycle after the fourth strobe. prog_addr and prog_data equal that fourth write's address and data.
- R3: The writes AAh@AAAh, 55h@555h, 80h@AAAh, AAh@AAAh, 55h@555h, 10h@AAAh raise chip_erase_pulse for one cycle after the sixth strobe.
- R4: The same five-write prefix followed by data 50h at any address raises sect_erase_pulse, with sect_idx equal to address bits 19:12 of that sixth write (4 KB sectors).
- R5: The same five-write prefix followed by data 30h at any address raises blk_erase_pulse, with blk_idx equal to address bits 19:16 of that sixth write (64 KB blocks).
- R6: The writes AAh@AAAh, 55h@555h, 90h@AAAh raise id_enter_pulse for one cycle and set id_mode. While id_mode is set, writes other than F0h change nothing.
- R7: While id_mode is 1, a read address with bits 19:1 all zero gives id_hit=1, with id_data=BFh when bit 0 is 0 and D8h when bit 0 is 1. Any other read address, or id_mode=0, gives id_hit=0 and id_data=00h.
- R8: While id_mode is set, a write of F0h at any address clears id_mode, raises id_exit_pulse for one cycle and leaves the decoder in read mode.
- R9: Command addresses are matched on bits 14:0 only. Bits 19:15 of a key or selector write may take any value.
- R10: A write that does not match the next expected cycle of a sequence returns the decoder to read mode. A later continuation of the abandoned sequence does not complete it.
- R11: A strobe with op_busy=1 is ignored. No pulse follows it, partial sequences and id_mode are kept, and an F0h write does not leave identification mode.
- R12: At most one pulse output is high in any cycle, and no pulse follows a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W (20) | Address of the write |
| wr_data | input | DATA_W (8) | Data of the write |
| op_busy | input | 1 | Internal program or erase running; writes are ignored |
| rd_addr | input | ADDR_W (20) | Read address for identification bytes |
| id_mode | output | 1 | Identification mode active |
| id_hit | output | 1 | The read address returns an identification byte |
| id_data | output | DATA_W (8) | Identification byte, 00h when id_hit is low |
| prog_pulse | output | 1 | Byte program command recognised |
| prog_addr | output | ADDR_W (20) | Target address, valid with prog_pulse |
| prog_data | output | DATA_W (8) | Byte to program, valid with prog_pulse |
| sect_erase_pulse | output | 1 | Sector erase command recognised |
| sect_idx | output | ADDR_W-SECT_LSB (8) | Sector index, valid with sect_erase_pulse |
| blk_erase_pulse | output | 1 | Block erase command recognised |
| blk_idx | output | ADDR_W-BLK_LSB (4) | Block index, valid with blk_erase_pulse |
| chip_erase_pulse | output | 1 | Chip erase command recognised |
| id_enter_pulse | output | 1 | Identification mode entered |
| id_exit_pulse | output | 1 | Identification mode left |

## Verification
A wrong sequence state can stay hidden until the final cycle of a command. It then shows as a missing pulse, a pulse of the wrong kind, or a pulse after an abandoned prefix, one cycle after that final strobe. For this reason the stimulus corrupts single cycles inside sequences and sets the high address bits at random, and every write is compared against an independent model. A wrong identification flag shows at once on id_mode and on the read port, and a wrongly ignored busy cycle shows as a pulse that should not exist or as an early exit from identification mode.

// File: rtl/unlock_cmd_pkg.sv
package unlock_cmd_pkg;

   localparam logic [7:0] KEY_D1    = 8'hAA;
   localparam logic [7:0] KEY_D2    = 8'h55;
   localparam logic [7:0] SEL_PGM   = 8'hA0;
   localparam logic [7:0] SEL_ERS   = 8'h80;
   localparam logic [7:0] SEL_ID    = 8'h90;
   localparam logic [7:0] ERS_CHIP  = 8'h10;
   localparam logic [7:0] ERS_SECT  = 8'h50;
   localparam logic [7:0] ERS_BLK   = 8'h30;
   localparam logic [7:0] ID_QUIT   = 8'hF0;
   localparam logic [31:0] KEY_A1   = 32'h0000_0AAA;
   localparam logic [31:0] KEY_A2   = 32'h0000_0555;

   typedef enum logic [2:0] {
      ST_READ = 3'd0,
      ST_U1   = 3'd1,
      ST_U2   = 3'd2,
      ST_PGM  = 3'd3,
      ST_E3   = 3'd4,
      ST_E4   = 3'd5,
      ST_E5   = 3'd6
   } seq_st_t;

   typedef struct packed {
      logic key1;
      logic key2;
      logic arm_pgm;
      logic arm_ers;
      logic arm_id;
      logic sel_chip;
      logic sel_sect;
      logic sel_blk;
      logic quit;
   } cyc_match_t;

   typedef struct packed {
      logic prog;
      logic sect;
      logic blk;
      logic chip;
      logic enter;
      logic leave;
   } cmd_ev_t;

endpackage

// File: rtl/cmd_cycle_match.sv
module cmd_cycle_match
   import unlock_cmd_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8,
   parameter int CMP_W  = 15
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output cyc_match_t        match
);

   localparam int EFF_W = (CMP_W < ADDR_W) ? CMP_W : ADDR_W;
   localparam logic [EFF_W-1:0] A1 = EFF_W'(KEY_A1);
   localparam logic [EFF_W-1:0] A2 = EFF_W'(KEY_A2);

   logic [EFF_W-1:0] a_cmp;
   logic             at_a1;
   logic             at_a2;

   generate
      if (CMP_W < ADDR_W) begin : g_masked
         assign a_cmp = addr[EFF_W-1:0];
      end else begin : g_full
         assign a_cmp = addr;
      end
   endgenerate

   assign at_a1 = (a_cmp == A1);
   assign at_a2 = (a_cmp == A2);

   always_comb begin
      match          = '0;
      match.key1     = at_a1 && (data == KEY_D1);
      match.key2     = at_a2 && (data == KEY_D2);
      match.arm_pgm  = at_a1 && (data == SEL_PGM);
      match.arm_ers  = at_a1 && (data == SEL_ERS);
      match.arm_id   = at_a1 && (data == SEL_ID);
      match.sel_chip = at_a1 && (data == ERS_CHIP);
      match.sel_sect = (data == ERS_SECT);
      match.sel_blk  = (data == ERS_BLK);
      match.quit     = (data == ID_QUIT);
   end

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
   import unlock_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic       busy,
   input  cyc_match_t match,
   output seq_st_t    state,
   output logic       id_mode,
   output cmd_ev_t    ev
);

   seq_st_t state_nx;
   logic    id_nx;
   cmd_ev_t ev_nx;
   logic    take;

   assign take = wr_stb && !busy;

   always_comb begin
      state_nx = state;
      id_nx    = id_mode;
      ev_nx    = '0;
      if (take) begin
         if (id_mode) begin
            if (match.quit) begin
               id_nx    = 1'b0;
               ev_nx.leave = 1'b1;
               state_nx = ST_READ;
            end
         end else begin
            case (state)
               ST_READ: state_nx = match.key1 ? ST_U1 : ST_READ;
               ST_U1:   state_nx = match.key2 ? ST_U2 : ST_READ;
               ST_U2: begin
                  state_nx = ST_READ;
                  if (match.arm_pgm)
                     state_nx = ST_PGM;
                  else if (match.arm_ers)
                     state_nx = ST_E3;
                  else if (match.arm_id) begin
                     id_nx       = 1'b1;
                     ev_nx.enter = 1'b1;
                  end
               end
               ST_PGM: begin
                  ev_nx.prog = 1'b1;
                  state_nx   = ST_READ;
               end
               ST_E3:   state_nx = match.key1 ? ST_E4 : ST_READ;
               ST_E4:   state_nx = match.key2 ? ST_E5 : ST_READ;
               ST_E5: begin
                  state_nx = ST_READ;
                  if (match.sel_chip)
                     ev_nx.chip = 1'b1;
                  else if (match.sel_sect)
                     ev_nx.sect = 1'b1;
                  else if (match.sel_blk)
                     ev_nx.blk = 1'b1;
               end
               default: state_nx = ST_READ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_READ;
         id_mode <= 1'b0;
         ev      <= '0;
      end else begin
         state   <= state_nx;
         id_mode <= id_nx;
         ev      <= ev_nx;
      end
   end

   // R11: a busy strobe leaves sequence and mode state unchanged
   p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && busy) |=> (state == $past(state)) && (id_mode == $past(id_mode)));

   // R12: one event at most, none without a strobe
   p_one_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ev));
   p_no_stb_no_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> (ev == '0));

   // R2: a program event only follows the armed state
   p_prog_from_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev.prog |-> ($past(state) == ST_PGM));

   // R6 / R8: mode flag agrees with entry and exit events
   p_enter_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev.enter |-> id_mode);
   p_exit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ev.leave |-> (!id_mode && state == ST_READ));

endmodule

// File: rtl/cmd_payload_reg.sv
module cmd_payload_reg #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (load) begin
         addr_q <= addr_in;
         data_q <= data_in;
      end
   end

   // payload only moves on an accepted write
   p_payload_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(addr_q) && $stable(data_q));

endmodule

// File: rtl/id_responder.sv
module id_responder #(
   parameter int          ADDR_W = 20,
   parameter int          DATA_W = 8,
   parameter logic [7:0]  MFR_ID = 8'hBF,
   parameter logic [7:0]  DEV_ID = 8'hD8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              id_hit,
   output logic [DATA_W-1:0] id_data
);

   logic upper_zero;

   assign upper_zero = (rd_addr[ADDR_W-1:1] == '0);
   assign id_hit     = id_mode && upper_zero;

   always_comb begin
      id_data = '0;
      if (id_hit)
         id_data = rd_addr[0] ? DATA_W'(DEV_ID) : DATA_W'(MFR_ID);
   end

   // R7: nothing is returned outside identification mode
   p_silent_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !id_mode |-> (!id_hit && id_data == '0));

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
   import unlock_cmd_pkg::*;
#(
   parameter int         ADDR_W   = 20,
   parameter int         DATA_W   = 8,
   parameter int         CMP_W    = 15,
   parameter int         SECT_LSB = 12,
   parameter int         BLK_LSB  = 16,
   parameter logic [7:0] MFR_ID   = 8'hBF,
   parameter logic [7:0] DEV_ID   = 8'hD8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_stb,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       op_busy,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic                       id_mode,
   output logic                       id_hit,
   output logic [DATA_W-1:0]          id_data,
   output logic                       prog_pulse,
   output logic [ADDR_W-1:0]          prog_addr,
   output logic [DATA_W-1:0]          prog_data,
   output logic                       sect_erase_pulse,
   output logic [ADDR_W-SECT_LSB-1:0] sect_idx,
   output logic                       blk_erase_pulse,
   output logic [ADDR_W-BLK_LSB-1:0]  blk_idx,
   output logic                       chip_erase_pulse,
   output logic                       id_enter_pulse,
   output logic                       id_exit_pulse
);

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("unlock_cmd_decoder: command codes need DATA_W of 8");
      end
      if (CMP_W < 12 || CMP_W > ADDR_W) begin : g_bad_cmp_w
         $error("unlock_cmd_decoder: CMP_W must cover the key addresses and fit ADDR_W");
      end
      if (SECT_LSB >= BLK_LSB || BLK_LSB >= ADDR_W) begin : g_bad_region
         $error("unlock_cmd_decoder: need SECT_LSB < BLK_LSB < ADDR_W");
      end
   endgenerate

   cyc_match_t match;
   seq_st_t    state;
   cmd_ev_t    ev;
   logic [ADDR_W-1:0] pay_addr;
   logic [DATA_W-1:0] pay_data;

   cmd_cycle_match #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CMP_W  (CMP_W)
   ) u_match (
      .addr  (wr_addr),
      .data  (wr_data),
      .match (match)
   );

   cmd_seq_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .busy    (op_busy),
      .match   (match),
      .state   (state),
      .id_mode (id_mode),
      .ev      (ev)
   );

   cmd_payload_reg #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_payload (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wr_stb && !op_busy),
      .addr_in (wr_addr),
      .data_in (wr_data),
      .addr_q  (pay_addr),
      .data_q  (pay_data)
   );

   id_responder #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MFR_ID (MFR_ID),
      .DEV_ID (DEV_ID)
   ) u_id (
      .clk     (clk),
      .rst_n   (rst_n),
      .id_mode (id_mode),
      .rd_addr (rd_addr),
      .id_hit  (id_hit),
      .id_data (id_data)
   );

   assign prog_pulse       = ev.prog;
   assign sect_erase_pulse = ev.sect;
   assign blk_erase_pulse  = ev.blk;
   assign chip_erase_pulse = ev.chip;
   assign id_enter_pulse   = ev.enter;
   assign id_exit_pulse    = ev.leave;
   assign prog_addr        = pay_addr;
   assign prog_data        = pay_data;
   assign sect_idx         = pay_addr[ADDR_W-1:SECT_LSB];
   assign blk_idx          = pay_addr[ADDR_W-1:BLK_LSB];

   // R11: no command pulse follows a busy strobe
   p_busy_no_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && op_busy) |=> !(prog_pulse || sect_erase_pulse || blk_erase_pulse ||
                                chip_erase_pulse || id_enter_pulse || id_exit_pulse));

   // R2: the program payload is the strobe that completed the sequence
   p_prog_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      prog_pulse |-> (prog_addr == $past(wr_addr)) && (prog_data == $past(wr_data)));

   // R1: sequences never run during identification mode
   p_id_idle_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
      id_mode |-> (state == ST_READ));

endmodule

// File: tb/unlock_cmd_decoder_test.sv
`timescale 1ns/1ps
module unlock_cmd_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [19:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        op_busy = 1'b0;
   logic [19:0] rd_addr = '0;
   logic        id_mode, id_hit;
   logic [7:0]  id_data;
   logic        prog_pulse, sect_erase_pulse, blk_erase_pulse, chip_erase_pulse;
   logic        id_enter_pulse, id_exit_pulse;
   logic [19:0] prog_addr;
   logic [7:0]  prog_data;
   logic [7:0]  sect_idx;
   logic [3:0]  blk_idx;

   int n_chk = 0;
   int n_bad = 0;

   // model state: 0 read,1 u1,2 u2,3 pgm,4 e3,5 e4,6 e5
   int          m_st = 0;
   bit          m_id = 0;
   logic [5:0]  e_ev;   // prog,sect,blk,chip,enter,exit
   logic [19:0] e_addr;
   logic [7:0]  e_data;

   always #2 clk = ~clk;

   unlock_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .op_busy(op_busy), .rd_addr(rd_addr), .id_mode(id_mode), .id_hit(id_hit),
      .id_data(id_data), .prog_pulse(prog_pulse), .prog_addr(prog_addr),
      .prog_data(prog_data), .sect_erase_pulse(sect_erase_pulse), .sect_idx(sect_idx),
      .blk_erase_pulse(blk_erase_pulse), .blk_idx(blk_idx),
      .chip_erase_pulse(chip_erase_pulse), .id_enter_pulse(id_enter_pulse),
      .id_exit_pulse(id_exit_pulse)
   );

   function automatic logic [5:0] ev_vec();
      return {prog_pulse, sect_erase_pulse, blk_erase_pulse, chip_erase_pulse,
              id_enter_pulse, id_exit_pulse};
   endfunction

   function automatic bit at(logic [19:0] a, logic [14:0] k);
      return a[14:0] == k;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // reference behaviour taken from the requirements
   task automatic model(logic [19:0] a, logic [7:0] d, bit b);
      e_ev = '0; e_addr = a; e_data = d;
      if (b) return;
      if (m_id) begin
         if (d == 8'hF0) begin m_id = 0; m_st = 0; e_ev[0] = 1; end
         return;
      end
      case (m_st)
         0: m_st = (at(a, 15'hAAA) && d == 8'hAA) ? 1 : 0;
         1: m_st = (at(a, 15'h555) && d == 8'h55) ? 2 : 0;
         2: begin
            m_st = 0;
            if (at(a, 15'hAAA) && d == 8'hA0) m_st = 3;
            else if (at(a, 15'hAAA) && d == 8'h80) m_st = 4;
            else if (at(a, 15'hAAA) && d == 8'h90) begin m_id = 1; e_ev[1] = 1; end
         end
         3: begin e_ev[5] = 1; m_st = 0; end
         4: m_st = (at(a, 15'hAAA) && d == 8'hAA) ? 5 : 0;
         5: m_st = (at(a, 15'h555) && d == 8'h55) ? 6 : 0;
         default: begin
            m_st = 0;
            if (at(a, 15'hAAA) && d == 8'h10) e_ev[2] = 1;
            else if (d == 8'h50) e_ev[4] = 1;
            else if (d == 8'h30) e_ev[3] = 1;
         end
      endcase
   endtask

   task automatic wr(logic [19:0] a, logic [7:0] d, bit b, string req);
      @(negedge clk);
      wr_stb = 1; wr_addr = a; wr_data = d; op_busy = b;
      model(a, d, b);
      @(posedge clk);
      #1;
      check(req, {26'd0, ev_vec()}, {26'd0, e_ev});
      if (e_ev[5]) begin
         check({req, " prog_addr"}, {12'd0, prog_addr}, {12'd0, e_addr});
         check({req, " prog_data"}, {24'd0, prog_data}, {24'd0, e_data});
      end
      if (e_ev[4]) check({req, " sect_idx"}, {24'd0, sect_idx}, {24'd0, e_addr[19:12]});
      if (e_ev[3]) check({req, " blk_idx"}, {28'd0, blk_idx}, {28'd0, e_addr[19:16]});
      check({req, " id_mode"}, {31'd0, id_mode}, {31'd0, m_id});
      @(negedge clk);
      wr_stb = 0; op_busy = 0;
   endtask

   task automatic rd(logic [19:0] a, string req);
      bit hit;
      @(negedge clk);
      rd_addr = a;
      #1;
      hit = m_id && (a[19:1] == 0);
      check({req, " hit"}, {31'd0, id_hit}, {31'd0, hit});
      check({req, " data"}, {24'd0, id_data}, hit ? (a[0] ? 32'hD8 : 32'hBF) : 32'h0);
   endtask

   task automatic hi5(output logic [4:0] h);
      h = 5'($urandom);
   endtask

   task automatic key2(string req);
      logic [4:0] h;
      hi5(h); wr({h, 15'hAAA}, 8'hAA, 0, req);
      hi5(h); wr({h, 15'h555}, 8'h55, 0, req);
   endtask

   initial begin : watchdog
      #(4ns * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4711));
      repeat (4) @(posedge clk);
      #1;
      check("R1 pulses after reset", {26'd0, ev_vec()}, 32'd0);
      check("R1 id_mode after reset", {31'd0, id_mode}, 32'd0);
      @(negedge clk); rst_n = 1;

      // R2 program
      key2("R2"); wr(20'h00AAA, 8'hA0, 0, "R2");
      wr(20'hC1234, 8'h5A, 0, "R2 program write");
      // R3 chip erase
      key2("R3"); wr(20'h00AAA, 8'h80, 0, "R3"); key2("R3");
      wr(20'h00AAA, 8'h10, 0, "R3 chip erase");
      // R4 sector erase
      key2("R4"); wr(20'h00AAA, 8'h80, 0, "R4"); key2("R4");
      wr(20'hA7123, 8'h50, 0, "R4 sector erase");
      // R5 block erase
      key2("R5"); wr(20'h00AAA, 8'h80, 0, "R5"); key2("R5");
      wr(20'h5F00F, 8'h30, 0, "R5 block erase");
      // R9 high bits on keys
      wr(20'hF8AAA, 8'hAA, 0, "R9"); wr(20'h78555, 8'h55, 0, "R9");
      wr(20'h88AAA, 8'hA0, 0, "R9"); wr(20'h00001, 8'h00, 0, "R9 program with high key bits");
      // R10 mismatch abandons sequence
      key2("R10"); wr(20'h00AAB, 8'h80, 0, "R10 bad third address");
      key2("R10"); wr(20'h00AAA, 8'h10, 0, "R10 continuation after abort");
      wr(20'h00AAA, 8'hAA, 0, "R10"); wr(20'h00555, 8'h54, 0, "R10 bad key data");
      wr(20'h00AAA, 8'hA0, 0, "R10"); wr(20'h00123, 8'h11, 0, "R10 no program after abort");
      // R6/R7 ID mode
      rd(20'h00000, "R7 off");
      key2("R6"); wr(20'h00AAA, 8'h90, 0, "R6 enter");
      rd(20'h00000, "R7 mfr"); rd(20'h00001, "R7 dev"); rd(20'h00002, "R7 other");
      rd(20'h80001, "R7 high");
      wr(20'h00AAA, 8'hAA, 0, "R6 write ignored in id");
      rd(20'h00001, "R6 still id");
      // R11 busy blocks exit
      wr(20'h12345, 8'hF0, 1, "R11 busy exit ignored");
      rd(20'h00000, "R11 still id");
      // R8 exit
      wr(20'h3C3C3, 8'hF0, 0, "R8 exit");
      rd(20'h00000, "R8 after exit");
      // R11 busy mid-sequence keeps partial state
      key2("R11"); wr(20'h00AAA, 8'h10, 1, "R11 busy in sequence");
      wr(20'h00AAA, 8'hA0, 0, "R11"); wr(20'h0BEEF, 8'h77, 0, "R11 sequence survives busy");
      // R12 idle cycles: no pulse
      repeat (3) begin
         @(negedge clk); #1;
         check("R12 idle", {26'd0, ev_vec()}, 32'd0);
      end

      // random command mix with corruption
      for (int i = 0; i < 400; i++) begin
         int kind = int'($urandom_range(0, 5));
         int len  = (kind < 3) ? 4 : 6;
         for (int c = 0; c < len; c++) begin
            logic [19:0] a;
            logic [7:0]  d;
            a = $urandom; a[14:0] = (c == 1 || c == 4) ? 15'h555 : 15'hAAA;
            d = (c == 1 || c == 4) ? 8'h55 : 8'hAA;
            if (c == 2) d = (kind == 0) ? 8'hA0 : (kind == 1) ? 8'h90 : (kind == 2) ? 8'hF0 : 8'h80;
            if (kind == 0 && c == 3) begin a = $urandom; d = $urandom; end
            if (c == 5) begin
               d = (kind == 3) ? 8'h10 : (kind == 4) ? 8'h50 : 8'h30;
               if (kind != 3) a = $urandom;
            end
            if ($urandom_range(0, 19) == 0) d = $urandom;
            if ($urandom_range(0, 29) == 0) a[3:0] = $urandom;
            wr(a, d, $urandom_range(0, 9) == 0, "R12 random");
            if (kind == 2 && c == 2) break;
         end
         if ($urandom_range(0, 3) == 0) rd({19'd0, 1'($urandom)}, "R7 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule